// File: doc/BRIEF.md
# Memory Card Block DMA Engine

This block moves one data block between system RAM and the data path of a memory card, so the processor never copies payload words itself. The processor writes a single start-address register. When the command path reports that a single-block read or a single-block write command has completed without error, the engine starts without further prompting. For a card write it reads words from RAM through a bus master port and queues them in a transmit FIFO for the card-side serializer. For a card read it takes the words the card side pushes into a receive FIFO and writes them to RAM through the same master port.

Transfers are half-duplex, so one address register serves both directions and the command just issued decides whether it is a source or a destination address. A working pointer copied from it at the start steps by one word (4 bytes) per accepted bus beat. The register itself is never changed by a transfer. A FIFO that runs dry on the card-write side, or overflows on the card-read side, ends the transfer with an error pulse in place of the completion pulse.

Top module: `cardDmaEngine`

## Requirements
- R1: A cycle with `cmdDone`, `cmdOk` high and `cmdIndex` equal to 17 (card read) or 24 (card write) while idle starts a transfer; `busy` is high from the next cycle.
- R2: For command 24 the engine issues bus reads (`busWe` low) at the start address, then each following address 4 bytes higher. The words read are handed to the card side through `cardTxWord` in the same order.
- R3: For command 17 the words pushed through `cardRxWord` are written to RAM (`busWe` high) in push order, at the start address and then 4 bytes higher per word.
- R4: One start register, loaded by `addrWrEn`, serves both directions. A transfer never modifies it, so a later transfer with no new write starts at the same address.
- R5: `busStb` stays high, with a stable address, until `busAck`. A transfer performs exactly BLOCK_BYTES/4 accepted beats, and no beat is requested while the transmit FIFO is full or the receive FIFO is empty.
- R6: During a card write, a `cardPop` while `cardTxEmpty` is high and words remain ends the transfer with a one-cycle `xferErr` and no `xferDone`.
- R7: During a card read, a `cardPush` while `cardRxFull` is high and words remain ends the transfer with a one-cycle `xferErr` and no `xferDone`.
- R8: After every word has been moved on both sides without a fault, `xferDone` pulses for exactly one cycle, in the cycle `busy` falls. `xferDone` and `xferErr` are never high together.
- R9: A `cmdDone` with `cmdOk` low, or with any other index, starts nothing. `busy` and `busStb` stay low, and the FIFO state seen on `cardRxFull`/`cardTxEmpty` is unchanged.
- R10: `cardPop` and `cardPush` while idle are ignored: no error pulse and no change to the FIFO flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrWrEn | input | 1 | Load the start-address register |
| addrWrData | input | ADDR_W | Start address value |
| cmdDone | input | 1 | Command path finished a command |
| cmdOk | input | 1 | That command completed without error |
| cmdIndex | input | CMD_W | Index of the finished command |
| busStb | output | 1 | Bus master request, held until acknowledge |
| busWe | output | 1 | 1 = write to RAM, 0 = read from RAM |
| busAddr | output | ADDR_W | Byte address of the current beat |
| busWdata | output | DATA_W | Data for a RAM write |
| busRdata | input | DATA_W | Data returned by a RAM read |
| busAck | input | 1 | Slave accepts the beat |
| cardPop | input | 1 | Card side takes one transmit word |
| cardTxWord | output | DATA_W | Head word of the transmit FIFO |
| cardTxEmpty | output | 1 | Transmit FIFO empty |
| cardPush | input | 1 | Card side delivers one received word |
| cardRxWord | input | DATA_W | Received word |
| cardRxFull | output | 1 | Receive FIFO full |
| busy | output | 1 | A transfer is in progress |
| xferDone | output | 1 | One-cycle pulse: block moved without fault |
| xferErr | output | 1 | One-cycle pulse: FIFO underrun or overrun |

## Verification
`busy` rises one cycle after the qualifying `cmdDone` cycle. A bus beat counts in the cycle where `busStb` and `busAck` are both high, and the pointer advances one cycle later. `xferDone` or `xferErr` appears one cycle after the cycle in which the last count update or the fault was registered. The bench drives inputs and samples outputs on the falling edge. A scoreboard queue holds the expected address and data of every beat, and a monitor pops it in the exact cycle each beat is accepted. Pulse counts are compared only after the register stages have settled, so a late, missing or repeated pulse shows up as a count mismatch.

// File: rtl/cardDmaPkg.sv
package cardDmaPkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CARD_WR = 2'd1,
    ST_CARD_RD = 2'd2
  } dmaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic start;
    logic active;
    logic dirRead;
  } dmaCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic allMoved;
    logic fifoFault;
  } dmaStat_t;

endpackage

// File: rtl/cardDmaFifo.sv
module cardDmaFifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             full,
  output logic             empty
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [LVL_W-1:0] level;
  logic doPush, doPop;

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = store[rdIdx];

  always_ff @(posedge clk) begin
    if (doPush) store[wrIdx] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrIdx <= '0;
      rdIdx <= '0;
      level <= '0;
    end else begin
      if (doPush) wrIdx <= stepIdx(wrIdx);
      if (doPop)  rdIdx <= stepIdx(rdIdx);
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/cardDmaControl.sv
module cardDmaControl
  import cardDmaPkg::*;
#(
  parameter int CMD_W  = 6,
  parameter int RD_CMD = 17,
  parameter int WR_CMD = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdDone,
  input  logic             cmdOk,
  input  logic [CMD_W-1:0] cmdIndex,
  input  dmaStat_t         stat,
  output dmaCtrl_t         ctrl,
  output logic             busy,
  output logic             xferDone,
  output logic             xferErr
);

  dmaState_e state, stateNext;
  logic isRdCmd, isWrCmd, trigger;

  assign isRdCmd = (cmdIndex == CMD_W'(RD_CMD));
  assign isWrCmd = (cmdIndex == CMD_W'(WR_CMD));
  assign trigger = (state == ST_IDLE) && cmdDone && cmdOk && (isRdCmd || isWrCmd);

  assign ctrl.start   = trigger;
  assign ctrl.active  = (state != ST_IDLE);
  assign ctrl.dirRead = (state == ST_CARD_RD);
  assign busy         = ctrl.active;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (trigger) stateNext = isRdCmd ? ST_CARD_RD : ST_CARD_WR;
      end
      ST_CARD_WR, ST_CARD_RD: begin
        if (stat.fifoFault || stat.allMoved) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      xferDone <= 1'b0;
      xferErr  <= 1'b0;
    end else begin
      state    <= stateNext;
      xferErr  <= ctrl.active && stat.fifoFault;
      xferDone <= ctrl.active && !stat.fifoFault && stat.allMoved;
    end
  end

endmodule

// File: rtl/cardDmaDatapath.sv
module cardDmaDatapath
  import cardDmaPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BLOCK_BYTES = 512,
  parameter int FIFO_DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaCtrl_t          ctrl,
  output dmaStat_t          stat,
  input  logic              addrWrEn,
  input  logic [ADDR_W-1:0] addrWrData,
  output logic              busStb,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busAck,
  input  logic              cardPop,
  output logic [DATA_W-1:0] cardTxWord,
  output logic              cardTxEmpty,
  input  logic              cardPush,
  input  logic [DATA_W-1:0] cardRxWord,
  output logic              cardRxFull
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam int WORDS      = BLOCK_BYTES / WORD_BYTES;
  localparam int CNT_W      = $clog2(WORDS + 1);

  logic [ADDR_W-1:0] startAddr, ptr;
  logic [CNT_W-1:0]  beatCnt, cardCnt;
  logic txFull, txEmpty, rxFull, rxEmpty;
  logic [DATA_W-1:0] txHead, rxHead;
  logic beatsLeft, cardLeft, beatGo, cardGo;
  logic cardWant, fifoBlocked;

  assign beatsLeft = (beatCnt != CNT_W'(WORDS));
  assign cardLeft  = (cardCnt != CNT_W'(WORDS));

  // bus side: no beat without room (write) or data (read)
  assign busStb   = ctrl.active && beatsLeft && (ctrl.dirRead ? !rxEmpty : !txFull);
  assign busWe    = ctrl.dirRead;
  assign busAddr  = ptr;
  assign busWdata = rxHead;
  assign beatGo   = busStb && busAck;

  // card side
  assign cardWant    = ctrl.active && cardLeft && (ctrl.dirRead ? cardPush : cardPop);
  assign fifoBlocked = ctrl.dirRead ? rxFull : txEmpty;
  assign cardGo      = cardWant && !fifoBlocked;

  assign stat.fifoFault = cardWant && fifoBlocked;
  assign stat.allMoved  = !beatsLeft && !cardLeft;

  assign cardTxWord  = txHead;
  assign cardTxEmpty = txEmpty;
  assign cardRxFull  = rxFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startAddr <= '0;
    end else if (addrWrEn) begin
      startAddr <= addrWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      beatCnt <= '0;
      cardCnt <= '0;
    end else if (ctrl.start) begin
      ptr     <= startAddr;
      beatCnt <= '0;
      cardCnt <= '0;
    end else begin
      if (beatGo) begin
        ptr     <= ptr + ADDR_W'(WORD_BYTES);
        beatCnt <= beatCnt + 1'b1;
      end
      if (cardGo) cardCnt <= cardCnt + 1'b1;
    end
  end

  cardDmaFifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) txFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (ctrl.start),
    .push     (beatGo && !ctrl.dirRead),
    .pushData (busRdata),
    .pop      (cardGo && !ctrl.dirRead),
    .popData  (txHead),
    .full     (txFull),
    .empty    (txEmpty)
  );

  cardDmaFifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) rxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (ctrl.start),
    .push     (cardGo && ctrl.dirRead),
    .pushData (cardRxWord),
    .pop      (beatGo && ctrl.dirRead),
    .popData  (rxHead),
    .full     (rxFull),
    .empty    (rxEmpty)
  );

endmodule

// File: rtl/cardDmaEngine.sv
module cardDmaEngine
  import cardDmaPkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int BLOCK_BYTES = 512,
  parameter int FIFO_DEPTH  = 8,
  parameter int CMD_W       = 6,
  parameter int RD_CMD      = 17,
  parameter int WR_CMD      = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrWrEn,
  input  logic [ADDR_W-1:0] addrWrData,
  input  logic              cmdDone,
  input  logic              cmdOk,
  input  logic [CMD_W-1:0]  cmdIndex,
  output logic              busStb,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busAck,
  input  logic              cardPop,
  output logic [DATA_W-1:0] cardTxWord,
  output logic              cardTxEmpty,
  input  logic              cardPush,
  input  logic [DATA_W-1:0] cardRxWord,
  output logic              cardRxFull,
  output logic              busy,
  output logic              xferDone,
  output logic              xferErr
);

  dmaCtrl_t ctrl;
  dmaStat_t stat;

  cardDmaControl #(.CMD_W(CMD_W), .RD_CMD(RD_CMD), .WR_CMD(WR_CMD)) control (
    .clk      (clk),
    .rstN     (rstN),
    .cmdDone  (cmdDone),
    .cmdOk    (cmdOk),
    .cmdIndex (cmdIndex),
    .stat     (stat),
    .ctrl     (ctrl),
    .busy     (busy),
    .xferDone (xferDone),
    .xferErr  (xferErr)
  );

  cardDmaDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .BLOCK_BYTES(BLOCK_BYTES), .FIFO_DEPTH(FIFO_DEPTH)
  ) datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .stat        (stat),
    .addrWrEn    (addrWrEn),
    .addrWrData  (addrWrData),
    .busStb      (busStb),
    .busWe       (busWe),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .busAck      (busAck),
    .cardPop     (cardPop),
    .cardTxWord  (cardTxWord),
    .cardTxEmpty (cardTxEmpty),
    .cardPush    (cardPush),
    .cardRxWord  (cardRxWord),
    .cardRxFull  (cardRxFull)
  );

endmodule

// File: rtl/cardDmaChecker.sv
module cardDmaChecker #(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 6,
  parameter int RD_CMD = 17,
  parameter int WR_CMD = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdDone,
  input logic              cmdOk,
  input logic [CMD_W-1:0]  cmdIndex,
  input logic              busStb,
  input logic              busAck,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busy,
  input logic              xferDone,
  input logic              xferErr
);

  logic dataCmd;
  assign dataCmd = (cmdIndex == CMD_W'(RD_CMD)) || (cmdIndex == CMD_W'(WR_CMD));

  assert_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdDone && cmdOk && dataCmd) |=> busy);

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdDone && !(cmdOk && dataCmd)) |=> !busy);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busStb);

  assert_hold_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busStb && !busAck) |=> (busStb || xferErr));

  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busStb && !busAck) |=> (xferErr || $stable(busAddr)));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busStb && busAck) |=> (busAddr == $past(busAddr) + ADDR_W'(4)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  assert_done_err_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(xferDone && xferErr));

endmodule

bind cardDmaEngine cardDmaChecker #(
  .ADDR_W(ADDR_W), .CMD_W(CMD_W), .RD_CMD(RD_CMD), .WR_CMD(WR_CMD)
) checkerInst (
  .clk      (clk),
  .rstN     (rstN),
  .cmdDone  (cmdDone),
  .cmdOk    (cmdOk),
  .cmdIndex (cmdIndex),
  .busStb   (busStb),
  .busAck   (busAck),
  .busAddr  (busAddr),
  .busy     (busy),
  .xferDone (xferDone),
  .xferErr  (xferErr)
);

// File: tb/cardDmaEngine_test.sv
`timescale 1ns/1ps
module cardDmaEngine_test;

  localparam int WORDS = 128;
  localparam int DEPTH = 8;

  typedef struct {
    logic [31:0] addr;
    logic        we;
    logic [31:0] data;
  } beat_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrWrEn = 1'b0;
  logic [31:0] addrWrData = '0;
  logic cmdDone = 1'b0, cmdOk = 1'b0;
  logic [5:0] cmdIndex = '0;
  logic busStb, busWe, busAck;
  logic [31:0] busAddr, busWdata, busRdata;
  logic cardPop = 1'b0, cardPush = 1'b0;
  logic [31:0] cardTxWord, cardRxWord;
  logic cardTxEmpty, cardRxFull, busy, xferDone, xferErr;

  int nChecks = 0, nFail = 0;
  int doneCnt = 0, errCnt = 0, stbCycles = 0;
  int ackDelay = 0, waitCnt = 0;
  logic [31:0] mem [0:1023];
  beat_t expBeats[$];
  logic [31:0] expTx[$];

  always #5 clk = ~clk;

  cardDmaEngine uut (
    .clk(clk), .rstN(rstN), .addrWrEn(addrWrEn), .addrWrData(addrWrData),
    .cmdDone(cmdDone), .cmdOk(cmdOk), .cmdIndex(cmdIndex),
    .busStb(busStb), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busAck(busAck),
    .cardPop(cardPop), .cardTxWord(cardTxWord), .cardTxEmpty(cardTxEmpty),
    .cardPush(cardPush), .cardRxWord(cardRxWord), .cardRxFull(cardRxFull),
    .busy(busy), .xferDone(xferDone), .xferErr(xferErr)
  );

  function automatic logic [31:0] memInit(input int i);
    return 32'h5A000000 ^ (i * 32'h00010003);
  endfunction

  function automatic logic [31:0] rdWord(input int i);
    return 32'hC0DE0000 + i * 7;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // RAM slave model
  always @(posedge clk) begin
    if (!rstN) begin
      busAck <= 1'b0;
      busRdata <= '0;
      waitCnt <= 0;
    end else if (busAck) begin
      busAck <= 1'b0;
    end else if (busStb) begin
      if (waitCnt >= ackDelay) begin
        busAck <= 1'b1;
        waitCnt <= 0;
        if (busWe) mem[busAddr[11:2]] <= busWdata;
        else busRdata <= mem[busAddr[11:2]];
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end else begin
      waitCnt <= 0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (busStb) stbCycles++;
      if (xferDone) doneCnt++;
      if (xferErr) errCnt++;
      if (busStb && busAck) begin
        if (expBeats.size() == 0) begin
          check(1'b0, "R5 unexpected bus beat", busAddr, 32'h0);
        end else begin
          beat_t e;
          e = expBeats.pop_front();
          check(busAddr == e.addr, e.we ? "R3 beat address" : "R2 beat address", busAddr, e.addr);
          check(busWe == e.we, "R2/R3 beat direction", {31'd0, busWe}, {31'd0, e.we});
          if (e.we) check(busWdata == e.data, "R3 RAM write data", busWdata, e.data);
        end
      end
    end
  end

  task automatic expectBlock(input logic [31:0] base, input bit rd);
    for (int i = 0; i < WORDS; i++) begin
      beat_t b;
      b.addr = base + 32'(4 * i);
      b.we = rd;
      b.data = rd ? rdWord(i) : 32'h0;
      expBeats.push_back(b);
      if (!rd) expTx.push_back(memInit(int'(base >> 2) + i));
    end
  endtask

  task automatic setAddr(input logic [31:0] a);
    @(negedge clk);
    addrWrEn = 1'b1;
    addrWrData = a;
    @(negedge clk);
    addrWrEn = 1'b0;
  endtask

  task automatic issueCmd(input logic ok, input logic [5:0] idx);
    @(negedge clk);
    cmdDone = 1'b1;
    cmdOk = ok;
    cmdIndex = idx;
    @(negedge clk);
    cmdDone = 1'b0;
    cmdOk = 1'b0;
  endtask

  task automatic cardWriteRun(input int gap);
    for (int i = 0; i < WORDS; i++) begin
      logic [31:0] e;
      while (cardTxEmpty) @(negedge clk);
      e = expTx.pop_front();
      check(cardTxWord == e, "R2 card word order", cardTxWord, e);
      cardPop = 1'b1;
      @(negedge clk);
      cardPop = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic cardReadRun(input int gap);
    for (int i = 0; i < WORDS; i++) begin
      while (cardRxFull) @(negedge clk);
      cardPush = 1'b1;
      cardRxWord = rdWord(i);
      @(negedge clk);
      cardPush = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic finishXfer(input int d0, input int e0, input string tag);
    int guard = 0;
    while (busy && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
    check(doneCnt == d0 + 1, {tag, " R8 one done pulse"}, 32'(doneCnt - d0), 32'd1);
    check(errCnt == e0, {tag, " R8 no error pulse"}, 32'(errCnt - e0), 32'd0);
    check(expBeats.size() == 0, {tag, " R5 all beats done"}, 32'(expBeats.size()), 32'd0);
    check(!busy, {tag, " R8 idle after done"}, {31'd0, busy}, 32'd0);
  endtask

  initial begin
    int d0, e0, s0;
    for (int i = 0; i < 1024; i++) mem[i] = memInit(i);
    cardRxWord = '0;
    repeat (3) @(negedge clk);
    check(!busStb && !busy, "reset bus and busy low", {30'd0, busStb, busy}, 32'd0);
    check(!xferDone && !xferErr, "reset pulses low", {30'd0, xferDone, xferErr}, 32'd0);
    check(cardTxEmpty && !cardRxFull, "reset FIFO flags", {30'd0, cardTxEmpty, cardRxFull}, 32'd2);
    rstN = 1'b1;

    // card write from A (R1, R2)
    setAddr(32'h0000_0100);
    expectBlock(32'h0000_0100, 1'b0);
    d0 = doneCnt; e0 = errCnt;
    issueCmd(1'b1, 6'd24);
    check(busy, "R1 busy after write command", {31'd0, busy}, 32'd1);
    cardWriteRun(3);
    finishXfer(d0, e0, "write A");

    // card read, register not rewritten: still A (R3, R4)
    ackDelay = 2;
    expectBlock(32'h0000_0100, 1'b1);
    d0 = doneCnt; e0 = errCnt;
    issueCmd(1'b1, 6'd17);
    check(busy, "R1 busy after read command", {31'd0, busy}, 32'd1);
    cardReadRun(0);
    finishXfer(d0, e0, "read A");
    check(mem[64] == rdWord(0) && mem[64 + WORDS - 1] == rdWord(WORDS - 1),
          "R3 RAM contents", mem[64 + WORDS - 1], rdWord(WORDS - 1));

    // card write from B with slow card, fast bus: FIFO fills (R5)
    ackDelay = 0;
    setAddr(32'h0000_0800);
    expectBlock(32'h0000_0800, 1'b0);
    d0 = doneCnt; e0 = errCnt;
    issueCmd(1'b1, 6'd24);
    cardWriteRun(10);
    finishXfer(d0, e0, "write B");

    // underrun (R6)
    ackDelay = 20;
    d0 = doneCnt; e0 = errCnt;
    issueCmd(1'b1, 6'd24);
    cardPop = 1'b1;
    @(negedge clk);
    cardPop = 1'b0;
    repeat (3) @(negedge clk);
    check(errCnt == e0 + 1, "R6 underrun error pulse", 32'(errCnt - e0), 32'd1);
    check(doneCnt == d0, "R6 no done on underrun", 32'(doneCnt - d0), 32'd0);
    check(!busy, "R6 transfer ended", {31'd0, busy}, 32'd0);

    // overrun (R7)
    ackDelay = 1000;
    d0 = doneCnt; e0 = errCnt;
    issueCmd(1'b1, 6'd17);
    for (int i = 0; i <= DEPTH; i++) begin
      cardPush = 1'b1;
      cardRxWord = 32'(i);
      @(negedge clk);
    end
    cardPush = 1'b0;
    repeat (3) @(negedge clk);
    check(errCnt == e0 + 1, "R7 overrun error pulse", 32'(errCnt - e0), 32'd1);
    check(doneCnt == d0, "R7 no done on overrun", 32'(doneCnt - d0), 32'd0);
    check(!busy && cardRxFull, "R7 ended with FIFO full", {30'd0, busy, cardRxFull}, 32'd1);
    ackDelay = 0;

    // ignored commands (R9)
    s0 = stbCycles; e0 = errCnt; d0 = doneCnt;
    issueCmd(1'b0, 6'd17);
    check(!busy, "R9 failed read command ignored", {31'd0, busy}, 32'd0);
    issueCmd(1'b1, 6'd12);
    check(!busy, "R9 other index ignored", {31'd0, busy}, 32'd0);
    issueCmd(1'b0, 6'd24);
    repeat (5) @(negedge clk);
    check(stbCycles == s0, "R9 no bus request", 32'(stbCycles - s0), 32'd0);
    check(cardRxFull && cardTxEmpty, "R9 FIFO state untouched", {30'd0, cardRxFull, cardTxEmpty}, 32'd3);

    // idle card strobes (R10)
    cardPop = 1'b1;
    @(negedge clk);
    cardPop = 1'b0;
    cardPush = 1'b1;
    @(negedge clk);
    cardPush = 1'b0;
    repeat (3) @(negedge clk);
    check(errCnt == e0 && doneCnt == d0, "R10 idle strobes no pulse", 32'(errCnt - e0), 32'd0);
    check(cardRxFull && cardTxEmpty, "R10 FIFO flags unchanged", {30'd0, cardRxFull, cardTxEmpty}, 32'd3);

    // read after errors and ignored commands: register still B (R4)
    expectBlock(32'h0000_0800, 1'b1);
    d0 = doneCnt; e0 = errCnt;
    issueCmd(1'b1, 6'd17);
    check(!cardRxFull, "R4 FIFO flushed at start", {31'd0, cardRxFull}, 32'd0);
    cardReadRun(1);
    finishXfer(d0, e0, "read B R4");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule